// File: doc/BRIEF.md
# Fused 3x3 Convolution Dot-Product Unit

This unit produces one 3x3 convolution output per clock: the signed sum of nine pixel-by-weight products. It does not build nine separate multipliers and then add their products. All partial-product bits of the nine multiplications go into one shared bit matrix. That matrix is reduced column by column with full-adder counters until each column holds at most two bits, which gives a sum row and a carry row. A single carry-propagate adder turns that pair into the final value.

Signed operands use the Baugh-Wooley form, in which the partial-product bits that involve exactly one operand sign bit are inverted. The nine per-product correction terms are folded into a single constant at elaboration time, and the bits of that constant join the matrix as extra inputs. The surrounding datapath presents a new set of nine operand pairs with `in_valid` on any cycle. The matching result appears a fixed two cycles later, flagged by `out_valid`.

Top module: `conv3x3_fused`

## Requirements
- R1: With the default parameters (8-bit operands, nine taps), `out_result` is the exact sum of the nine signed products. Operands are 8-bit two's complement and the result is 20-bit two's complement.
- R2: Operands sampled with `in_valid` high at a rising edge produce `out_valid` high, with their result, after the second rising edge that follows it.
- R3: `in_valid` may stay high on every cycle. Each accepted operand set then yields its own result on consecutive cycles, in the order it was accepted.
- R4: `out_valid` is high only for accepted operand sets. A cycle with `in_valid` low creates no result.
- R5: `rst_n` is synchronous and active low. An edge with `rst_n` low forces `out_valid` low. Operand sets sampled during reset, or still in the pipeline when reset is applied, never produce a result.
- R6: Extreme operands give exact results without overflow. All -128 gives 147456, all +127 gives 145161, and pixels of -128 against weights of +127 give -146304.
- R7: Outside reset, `out_result` keeps its value while `out_valid` is low. Operand values presented with `in_valid` low do not change it.
- R8: Tap k takes bits [k*8 +: 8] of `in_pix` and the same bits of `in_wgt`. Each pixel is multiplied only by the weight at the same tap position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears the valid pipeline |
| in_valid | input | 1 | Operand set on `in_pix`/`in_wgt` is accepted this cycle |
| in_pix | input | N_TAPS*DATA_W | Nine signed pixels, tap k in bits [k*DATA_W +: DATA_W] |
| in_wgt | input | N_TAPS*DATA_W | Nine signed weights, same tap layout as `in_pix` |
| out_valid | output | 1 | `out_result` carries a new result this cycle |
| out_result | output | 2*DATA_W+clog2(N_TAPS) | Signed full-precision dot product |

## Verification
The bench builds the unit with its default parameters: nine taps of 8-bit operands and a 20-bit result. With these values the compensation constant sets bits in the upper columns. The column heights also reach the depth at which carries cascade through most of the result width. Single-tap stimuli exercise the mapping of each tap to its own columns. The all-minimum, all-maximum and mixed-sign sets exercise the inverted sign-bit terms and the top result bit. Random back-to-back runs, random bubbles and a reset applied with a result still in the pipeline cover the valid timing.

// File: rtl/conv_dp_pkg.sv
// Package conv_dp_pkg
// Shared elaboration-time helpers for the fused dot-product unit: the
// Baugh-Wooley correction constant summed over all taps, the number of
// partial-product bits per column, and the working depth the column
// compressor needs. Assumes operand widths of at least 2 bits.
package conv_dp_pkg;

    // Count of (i, j) index pairs with i + j == col, both in [0, dw).
    function automatic int pair_count(input int dw, input int col);
        int cnt;
        cnt = 0;
        for (int i = 0; i < dw; i++) begin
            if ((col - i >= 0) && (col - i < dw)) begin
                cnt++;
            end
        end
        return cnt;
    endfunction

    // Sum over all taps of the per-product signed correction, taken modulo 2**resw.
    function automatic longint comp_const(input int taps, input int dw, input int resw);
        longint per_prod;
        longint total;
        per_prod = (longint'(1) << dw) - (longint'(1) << (2 * dw - 1));
        total    = longint'(taps) * per_prod;
        return total & ((longint'(1) << resw) - 1);
    endfunction

    // Largest per-column list (bits plus sums written back) of the depth-first reduction.
    function automatic int fifo_depth(input int taps, input int dw, input int resw,
                                      input longint comp);
        int carries;
        int n;
        int fa;
        int deep;
        carries = 0;
        deep    = 4;
        for (int c = 0; c < resw; c++) begin
            n  = taps * pair_count(dw, c) + int'((comp >> c) & longint'(1)) + carries;
            fa = (n > 2) ? (n - 1) / 2 : 0;
            if (n + fa > deep) begin
                deep = n + fa;
            end
            carries = fa;
        end
        return deep;
    endfunction

endpackage

// File: rtl/bw_pp_gen.sv
// Module bw_pp_gen
// Produces the DATA_W x DATA_W partial-product bits of one signed product
// in Baugh-Wooley form. Bit (i, j) is a[i] & b[j] with weight 2**(i+j) and
// sits at index i*DATA_W + j. A bit that involves exactly one sign bit is
// inverted. The matching constant is not added here; the caller injects it
// once for all taps.
module bw_pp_gen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    output logic [DATA_W*DATA_W-1:0] pp
);
    localparam int MSB = DATA_W - 1;

    for (genvar i = 0; i < DATA_W; i++) begin : g_row
        for (genvar j = 0; j < DATA_W; j++) begin : g_col
            if ((i == MSB) != (j == MSB)) begin : g_inv
                // one operand sign bit: inverted term
                assign pp[i*DATA_W + j] = ~(a[i] & b[j]);
            end else begin : g_pos
                // both magnitude bits, or both sign bits: plain term
                assign pp[i*DATA_W + j] = a[i] & b[j];
            end
        end
    end
endmodule

// File: rtl/dfc_tree.sv
// Module dfc_tree
// Depth-first column compressor shared by all taps. For each column, from
// the least significant upward, it gathers the partial-product bits of
// every tap, the compensation bit and the carries from the column below.
// It reduces them with 3:2 counters until at most two bits remain. New sums
// go to the back of the column list, so later counters consume them. Carries
// are collected for the next column. The two remaining bits form one bit of
// sum_row and one of carry_row at the same weight. Carries out of the top
// column are dropped (modulo 2**RES_W). WORK_D must cover the deepest
// column list.
module dfc_tree #(
    parameter int               N_TAPS    = 9,
    parameter int               DATA_W    = 8,
    parameter int               RES_W     = 20,
    parameter logic [RES_W-1:0] COMP_BITS = '0,
    parameter int               WORK_D    = 256
) (
    input  logic [N_TAPS*DATA_W*DATA_W-1:0] pp_bits,
    output logic [RES_W-1:0]                sum_row,
    output logic [RES_W-1:0]                carry_row
);
    localparam int PP_N   = N_TAPS * DATA_W * DATA_W;
    localparam int PI_W   = $clog2(PP_N);
    localparam int WI_W   = $clog2(WORK_D);
    localparam int CI_W   = $clog2(RES_W);
    localparam int LOOP_N = WORK_D / 2 + 1;

    logic [WORK_D-1:0] work;
    logic [WORK_D-1:0] cin;
    logic [WORK_D-1:0] cout;
    int                wr;
    int                rd;
    int                n_ci;
    int                n_co;
    logic              xa;
    logic              xb;
    logic              xc;

    // Column-by-column reduction: each column is fully compressed before the next
    always_comb begin
        cin       = '0;
        cout      = '0;
        work      = '0;
        n_ci      = 0;
        n_co      = 0;
        wr        = 0;
        rd        = 0;
        xa        = 1'b0;
        xb        = 1'b0;
        xc        = 1'b0;
        sum_row   = '0;
        carry_row = '0;
        for (int c = 0; c < RES_W; c++) begin
            work = '0;
            cout = '0;
            wr   = 0;
            rd   = 0;
            n_co = 0;
            // gather this column's partial-product bits from every tap
            for (int t = 0; t < N_TAPS; t++) begin
                for (int i = 0; i < DATA_W; i++) begin
                    for (int j = 0; j < DATA_W; j++) begin
                        if (i + j == c) begin
                            work[WI_W'(wr)] = pp_bits[PI_W'((t*DATA_W + i)*DATA_W + j)];
                            wr++;
                        end
                    end
                end
            end
            // compensation constant bit
            if (COMP_BITS[CI_W'(c)]) begin
                work[WI_W'(wr)] = 1'b1;
                wr++;
            end
            // carries arrive last, so they enter the latest counters
            for (int k = 0; k < WORK_D; k++) begin
                if (k < n_ci) begin
                    work[WI_W'(wr)] = cin[WI_W'(k)];
                    wr++;
                end
            end
            // 3:2 counters until two bits or fewer remain
            for (int k = 0; k < LOOP_N; k++) begin
                if (wr - rd > 2) begin
                    xa = work[WI_W'(rd)];
                    xb = work[WI_W'(rd + 1)];
                    xc = work[WI_W'(rd + 2)];
                    rd = rd + 3;
                    work[WI_W'(wr)] = xa ^ xb ^ xc;
                    wr++;
                    cout[WI_W'(n_co)] = (xa & xb) | (xa & xc) | (xb & xc);
                    n_co++;
                end
            end
            if (wr - rd > 0) begin
                sum_row[CI_W'(c)] = work[WI_W'(rd)];
            end
            if (wr - rd > 1) begin
                carry_row[CI_W'(c)] = work[WI_W'(rd + 1)];
            end
            cin  = cout;
            n_ci = n_co;
        end
    end
endmodule

// File: rtl/final_cpa.sv
// Module final_cpa
// The only carry-propagate adder of the unit. It resolves the registered
// redundant sum and carry rows into the binary result, modulo 2**W.
// Assumes both rows already carry the same bit weights.
module final_cpa #(
    parameter int W = 20
) (
    input  logic [W-1:0] sum_row,
    input  logic [W-1:0] carry_row,
    output logic [W-1:0] total
);
    // single carry-propagate addition
    assign total = sum_row + carry_row;
endmodule

// File: rtl/conv3x3_fused.sv
// Module conv3x3_fused
// Top of the fused 3x3 convolution dot-product unit. It generates Baugh-Wooley
// partial products per tap, reduces all taps in one shared depth-first
// compressor, registers the redundant pair, resolves it with one adder and
// registers the result. The latency is fixed at two cycles with full
// throughput. Reset clears only the valid pipeline; data registers load
// only with valid data. Assumes N_TAPS >= 2 and DATA_W >= 2.
module conv3x3_fused #(
    parameter  int N_TAPS = 9,
    parameter  int DATA_W = 8,
    localparam int RES_W  = 2 * DATA_W + $clog2(N_TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [N_TAPS*DATA_W-1:0] in_pix,
    input  logic [N_TAPS*DATA_W-1:0] in_wgt,
    output logic                     out_valid,
    output logic [RES_W-1:0]         out_result
);
    localparam int               PP_W      = DATA_W * DATA_W;
    localparam longint           COMP_L    = conv_dp_pkg::comp_const(N_TAPS, DATA_W, RES_W);
    localparam logic [RES_W-1:0] COMP_BITS = COMP_L[RES_W-1:0];
    localparam int               WORK_D    = conv_dp_pkg::fifo_depth(N_TAPS, DATA_W, RES_W, COMP_L);

    logic [N_TAPS*PP_W-1:0] pp_flat;
    logic [RES_W-1:0]       tree_sum;
    logic [RES_W-1:0]       tree_carry;
    logic                   s1_valid;
    logic [RES_W-1:0]       s1_sum;
    logic [RES_W-1:0]       s1_carry;
    logic [RES_W-1:0]       cpa_total;

    // one partial-product generator per tap
    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        bw_pp_gen #(
            .DATA_W(DATA_W)
        ) i_ppg (
            .a (in_pix[t*DATA_W +: DATA_W]),
            .b (in_wgt[t*DATA_W +: DATA_W]),
            .pp(pp_flat[t*PP_W +: PP_W])
        );
    end

    dfc_tree #(
        .N_TAPS   (N_TAPS),
        .DATA_W   (DATA_W),
        .RES_W    (RES_W),
        .COMP_BITS(COMP_BITS),
        .WORK_D   (WORK_D)
    ) i_tree (
        .pp_bits  (pp_flat),
        .sum_row  (tree_sum),
        .carry_row(tree_carry)
    );

    // stage 1 valid: cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // stage 1 data: capture the redundant pair of an accepted set
    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_sum   <= tree_sum;
            s1_carry <= tree_carry;
        end
    end

    final_cpa #(
        .W(RES_W)
    ) i_cpa (
        .sum_row  (s1_sum),
        .carry_row(s1_carry),
        .total    (cpa_total)
    );

    // stage 2 valid: cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_valid;
    end

    // stage 2 data: load the resolved sum only for a valid stage-1 entry
    always_ff @(posedge clk) begin
        if (s1_valid) out_result <= cpa_total;
    end

    // ---------------- assertions ----------------
    logic signed [2*DATA_W-1:0] ref_prod [N_TAPS];
    logic        [RES_W-1:0]    ref_acc  [N_TAPS+1];
    logic        [RES_W-1:0]    ref_dot;
    logic        [1:0]          warm;

    // behavioural reference: sign-extended product sum per tap
    assign ref_acc[0] = '0;
    for (genvar t = 0; t < N_TAPS; t++) begin : g_ref
        assign ref_prod[t]  = $signed(in_pix[t*DATA_W +: DATA_W]) * $signed(in_wgt[t*DATA_W +: DATA_W]);
        assign ref_acc[t+1] = ref_acc[t] + {{(RES_W-2*DATA_W){ref_prod[t][2*DATA_W-1]}}, ref_prod[t]};
    end
    assign ref_dot = ref_acc[N_TAPS];

    // cycles since reset release, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R1: the redundant pair from the shared tree adds up to the product sum
    assert_pair_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (RES_W'(tree_sum + tree_carry) == ref_dot));

    // R1: the registered result equals the reference two cycles earlier
    assert_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && out_valid) |-> (out_result == $past(ref_dot, 2)));

    // R2: out_valid follows in_valid by exactly two edges
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R5: an edge with reset low leaves no valid result behind
    assert_reset_R5: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R7: result holds while no valid result is flagged
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !out_valid) |-> $stable(out_result));
endmodule

// File: tb/test_conv3x3_fused.sv
module test_conv3x3_fused;
    localparam int NT = 9;
    localparam int DW = 8;
    localparam int RW = 20;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NT*DW-1:0] in_pix = '0;
    logic [NT*DW-1:0] in_wgt = '0;
    logic          out_valid;
    logic [RW-1:0] out_result;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    int    q_exp[$];
    int    q_cyc[$];
    string q_tag[$];
    logic [RW-1:0] last_res = '0;
    bit    have_last = 1'b0;

    conv3x3_fused i_conv3x3_fused (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .in_wgt    (in_wgt),
        .out_valid (out_valid),
        .out_result(out_result)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int golden(input logic [NT*DW-1:0] p, input logic [NT*DW-1:0] w);
        int s = 0;
        for (int t = 0; t < NT; t++) begin
            s += int'($signed(p[t*DW +: DW])) * int'($signed(w[t*DW +: DW]));
        end
        return s;
    endfunction

    function automatic logic [NT*DW-1:0] rnd_vec();
        logic [NT*DW-1:0] v;
        for (int t = 0; t < NT; t++) v[t*DW +: DW] = DW'($urandom());
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // driver: present one operand set and push its expectation
    task automatic drive(input logic [NT*DW-1:0] p, input logic [NT*DW-1:0] w,
                         input bit expect_out, input string tag);
        @(negedge clk);
        in_pix   = p;
        in_wgt   = w;
        in_valid = 1'b1;
        if (expect_out) begin
            q_exp.push_back(golden(p, w));
            q_cyc.push_back(cyc);
            q_tag.push_back(tag);
        end
    endtask

    // idle cycles with random operands that must be ignored
    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_pix   = rnd_vec();
            in_wgt   = rnd_vec();
        end
    endtask

    // monitor: compare results against the scoreboard between edges
    always @(posedge clk) begin
        #2;
        if (!done) begin
            if (!rst_n) begin
                check(!out_valid, "R5 out_valid low in reset", int'(out_valid), 0);
                have_last = 1'b0;
            end else if (out_valid) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R4 unexpected out_valid", 1, 0);
                end else begin
                    int    e;
                    int    c;
                    string tg;
                    e  = q_exp.pop_front();
                    c  = q_cyc.pop_front();
                    tg = q_tag.pop_front();
                    check(int'($signed(out_result)) == e, {tg, " R1 value"}, int'($signed(out_result)), e);
                    check(cyc - c == 2, {tg, " R2 latency"}, cyc - c, 2);
                end
                last_res  = out_result;
                have_last = 1'b1;
            end else if (have_last) begin
                check(out_result == last_res, "R7 hold while idle", int'($signed(out_result)), int'($signed(last_res)));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (!done && cyc > WATCHDOG) begin
            check(1'b0, "watchdog expired", cyc, WATCHDOG);
            finish_up();
        end
    end

    initial begin
        logic [NT*DW-1:0] p;
        logic [NT*DW-1:0] w;
        // R5: operands offered during reset must never emerge
        rst_n    = 1'b0;
        in_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            in_pix = rnd_vec();
            in_wgt = rnd_vec();
        end
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        idle(4);

        // R8: one tap active at a time
        for (int t = 0; t < NT; t++) begin
            p = '0;
            w = '0;
            p[t*DW +: DW] = DW'(t + 2);
            w[t*DW +: DW] = DW'(-(3 * t + 1));
            drive(p, w, 1'b1, $sformatf("R8 tap %0d", t));
        end
        idle(3);

        // R6: extreme operands
        drive({NT{8'h80}}, {NT{8'h80}}, 1'b1, "R6 all -128");
        drive({NT{8'h7f}}, {NT{8'h7f}}, 1'b1, "R6 all +127");
        drive({NT{8'h80}}, {NT{8'h7f}}, 1'b1, "R6 -128 x +127");
        drive({NT{8'h7f}}, {NT{8'h80}}, 1'b1, "R6 +127 x -128");
        drive({{4{8'h80, 8'h7f}}, 8'h80}, {{4{8'h80, 8'h80}}, 8'h80}, 1'b1, "R6 mixed");
        drive('0, {NT{8'h80}}, 1'b1, "R6 zero pixels");
        idle(3);

        // R3: back-to-back random sets
        for (int k = 0; k < 200; k++) drive(rnd_vec(), rnd_vec(), 1'b1, "R3 burst");
        idle(3);

        // R4 and R7: random bubbles, ignored operands while in_valid is low
        for (int k = 0; k < 300; k++) begin
            if ($urandom() % 2 == 0) drive(rnd_vec(), rnd_vec(), 1'b1, "R4 bubbles");
            else idle(1);
        end
        idle(4);

        // R5: reset with a set still in flight; the first emerges, the second is dropped
        drive({NT{8'h11}}, {NT{8'h03}}, 1'b1, "R5 before reset");
        drive({NT{8'h22}}, {NT{8'h05}}, 1'b0, "R5 dropped");
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4);

        // recovery after reset
        for (int k = 0; k < 20; k++) drive(rnd_vec(), rnd_vec(), 1'b1, "R1 after reset");
        idle(6);

        check(q_exp.size() == 0, "R4 every accepted set delivered", q_exp.size(), 0);
        finish_up();
    end
endmodule